// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Stage

This block is a byte-wide streaming stage placed between a transmit DMA engine and a MAC transmitter. Frame bytes arrive on a valid/ready stream that carries start and end markers. Two per-frame control flags come with the first byte: one suppresses the frame check sequence and one suppresses padding. The stage passes the frame bytes through unchanged. If a frame is short and padding is allowed, the stage fills it with zero bytes up to the minimum payload length. It then adds a four-byte CRC-32 frame check sequence when that is requested, and always when padding was applied.

During padding and checksum emission the stage generates the bytes itself. It holds its input stalled and honours back-pressure from the MAC side. The end marker moves to the last byte that actually leaves the stage.

Top module: `eth_tx_pad_fcs`

## Requirements
- R1: Frame data bytes leave the stage unchanged and in order. The start marker is asserted only on the first output byte of a frame. After reset, out_valid is 0 and in_ready follows out_ready.
- R2: A frame is padded to exactly MIN_DATA (default 60) data-plus-pad bytes when its no-pad flag is 0 and it has fewer than MIN_DATA data bytes. Every pad byte is 0x00.
- R3: A padded frame always receives the four-byte FCS, even when its no-CRC flag is 1.
- R4: When the no-CRC flag is 0, four FCS bytes follow the data and pad bytes. The FCS is CRC-32 with reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and final inversion, computed over the data and pad bytes and sent least significant byte first.
- R5: When the no-CRC flag is 1 and no padding takes place, no FCS is added and the end marker stays on the final data byte.
- R6: When the no-pad flag is 1, a short frame leaves with no pad bytes at all.
- R7: Both flags are taken only from the beat that carries the start marker. Their values on later beats of the same frame have no effect.
- R8: While pad or FCS bytes are being emitted, in_ready is 0. out_last is asserted only on the final byte of the frame.
- R9: A frame with MIN_DATA or more data bytes is never padded.
- R10: A generated pad or FCS byte stays on the output, unchanged and valid, until out_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage accepts an input byte |
| in_data | input | 8 | Input frame byte |
| in_first | input | 1 | Input byte is the first of its frame |
| in_last | input | 1 | Input byte is the last of its frame |
| in_no_crc | input | 1 | Frame flag: no FCS requested (read on the first byte) |
| in_no_pad | input | 1 | Frame flag: padding forbidden (read on the first byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | MAC side accepts an output byte |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | Output byte starts the frame |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The critical coincidence is that the end-of-data decision (stop, pad or append the FCS) falls in the same cycle as flag capture. This happens when a one-byte frame carries start and end markers together, so the decision has to use the live flag inputs and not the held copies. The bench sweeps every frame length from 1 to 70 under all four flag combinations, which covers that case and both sides of the padding boundary. In a second pass it inverts the flags on every non-first beat and stalls both sides irregularly. Each received stream is judged byte for byte against a frame, pad and CRC that the bench builds arithmetically.

// File: rtl/eth_txpf_pkg.sv
// Package: shared state type, CRC constants and the CRC-32 byte step.
// Assumes byte-wide data and the reflected (LSB-first) CRC-32 form.
package eth_txpf_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } txpf_state_t;

    localparam int          FCS_BYTES     = 4;
    localparam int          FCS_IDX_W     = $clog2(FCS_BYTES);
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Advance a reflected CRC-32 register by one byte.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txpf_crc.sv
// CRC accumulator: folds every byte that leaves as data or pad into a
// running CRC-32. Restart makes the current byte start a new frame.
// Assumes the caller holds crc_q steady while FCS bytes are emitted.
module txpf_crc
    import eth_txpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_fire,
    input  logic        restart,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_q
);

    logic [31:0] crc_base;

    // Pick the seed for a first byte, else continue the frame.
    always_comb begin
        crc_base = restart ? CRC_SEED : crc_q;
    end

    // Register the updated CRC on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (byte_fire) begin
            crc_q <= crc32_step(crc_base, byte_in);
        end
    end

endmodule

// File: rtl/txpf_ctrl.sv
// Sequencer: tracks the data byte count, captures the frame flags on the
// first beat and steps DATA -> PAD -> FCS -> DATA. Assumes MIN_DATA >= 1
// and that in_first marks the first beat of every frame.
module txpf_ctrl
    import eth_txpf_pkg::*;
#(
    parameter int MIN_DATA = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_fire,
    input  logic                 out_fire,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic                 in_no_crc,
    input  logic                 in_no_pad,
    output txpf_state_t          state,
    output logic [FCS_IDX_W-1:0] fcs_idx,
    output logic                 data_is_final
);

    localparam int CNT_W = $clog2(MIN_DATA + 2);
    localparam logic [CNT_W:0]   MIN_EXT  = (CNT_W+1)'(MIN_DATA);
    localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(MIN_DATA - 1);
    localparam logic [FCS_IDX_W-1:0] IDX_LAST = FCS_IDX_W'(FCS_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hold_no_crc_q;
    logic             hold_no_pad_q;
    logic             eff_no_crc;
    logic             eff_no_pad;
    logic [CNT_W:0]   count_after;
    logic [CNT_W-1:0] count_sat;
    logic             need_pad;
    logic             add_fcs;

    // Flags come from the live inputs on a first beat, else from the held copy.
    always_comb begin
        eff_no_crc  = in_first ? in_no_crc : hold_no_crc_q;
        eff_no_pad  = in_first ? in_no_pad : hold_no_pad_q;
        count_after = (in_first ? '0 : {1'b0, cnt_q}) + 1'b1;
        count_sat   = (count_after > MIN_EXT) ? CNT_W'(MIN_DATA) : count_after[CNT_W-1:0];
        need_pad    = !eff_no_pad && (count_after < MIN_EXT);
        add_fcs     = need_pad || !eff_no_crc;
        data_is_final = in_last && !add_fcs;
    end

    // State, counter, FCS byte index and flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_DATA;
            cnt_q         <= '0;
            fcs_idx       <= '0;
            hold_no_crc_q <= 1'b0;
            hold_no_pad_q <= 1'b0;
        end else begin
            case (state)
                ST_DATA: begin
                    fcs_idx <= '0;
                    if (data_fire) begin
                        cnt_q <= count_sat;
                        if (in_first) begin
                            hold_no_crc_q <= in_no_crc;
                            hold_no_pad_q <= in_no_pad;
                        end
                        if (in_last) begin
                            if (need_pad) begin
                                state <= ST_PAD;
                            end else if (add_fcs) begin
                                state <= ST_FCS;
                            end
                        end
                    end
                end
                ST_PAD: begin
                    if (out_fire) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == PAD_LAST) begin
                            state <= ST_FCS;
                        end
                    end
                end
                ST_FCS: begin
                    if (out_fire) begin
                        fcs_idx <= fcs_idx + 1'b1;
                        if (fcs_idx == IDX_LAST) begin
                            state <= ST_DATA;
                            cnt_q <= '0;
                        end
                    end
                end
                default: state <= ST_DATA;
            endcase
        end
    end

endmodule

// File: rtl/eth_tx_pad_fcs.sv
// Top: forwards frame bytes, appends zero padding up to MIN_DATA bytes
// and a CRC-32 FCS as the frame flags and length require. Assumes
// well-formed frames (in_first and in_last on the proper beats).
module eth_tx_pad_fcs
    import eth_txpf_pkg::*;
#(
    parameter int MIN_DATA = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_no_crc,
    input  logic       in_no_pad,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last
);

    txpf_state_t          state;
    logic [FCS_IDX_W-1:0] fcs_idx;
    logic                 data_is_final;
    logic [31:0]          crc_q;
    logic [31:0]          fcs_word;
    logic                 data_fire;
    logic                 out_fire;
    logic                 crc_fire;

    // Output mux: pass-through in DATA, generated bytes otherwise.
    always_comb begin
        fcs_word  = ~crc_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_first = 1'b0;
        out_last  = 1'b0;
        case (state)
            ST_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_first = in_first;
                out_last  = data_is_final;
            end
            ST_PAD: begin
                out_valid = 1'b1;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_word[8*fcs_idx +: 8];
                out_last  = (fcs_idx == FCS_IDX_W'(FCS_BYTES - 1));
            end
            default: ;
        endcase
    end

    // Handshake strobes shared by the sequencer and the CRC.
    always_comb begin
        data_fire = in_valid && in_ready;
        out_fire  = out_valid && out_ready;
        crc_fire  = data_fire || (state == ST_PAD && out_fire);
    end

    txpf_ctrl #(.MIN_DATA(MIN_DATA)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_fire     (data_fire),
        .out_fire      (out_fire),
        .in_first      (in_first),
        .in_last       (in_last),
        .in_no_crc     (in_no_crc),
        .in_no_pad     (in_no_pad),
        .state         (state),
        .fcs_idx       (fcs_idx),
        .data_is_final (data_is_final)
    );

    txpf_crc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (crc_fire),
        .restart   (state == ST_DATA && in_first),
        .byte_in   (out_data),
        .crc_q     (crc_q)
    );

endmodule

// File: rtl/txpf_checker.sv
// Checker: temporal properties of the pad/FCS stage, bound to the top.
module txpf_checker
    import eth_txpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_ready,
    input  logic        in_last,
    input  logic        out_valid,
    input  logic        out_ready,
    input  logic [7:0]  out_data,
    input  logic        out_first,
    input  logic        out_last,
    input  txpf_state_t st
);

    // Generated bytes never carry the start marker.
    assert_no_first_on_append_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA && out_valid) |-> !out_first);

    // Pad bytes are zero.
    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD && out_valid) |-> (out_data == 8'h00));

    // Padding is always followed by the FCS, never straight back to data.
    assert_pad_then_fcs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |=> (st == ST_PAD || st == ST_FCS));

    // FCS emission does not end before its final byte.
    assert_fcs_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCS && out_valid && out_ready && !out_last) |=> (st == ST_FCS));

    // After the last data byte is taken without ending the frame, input stalls.
    assert_input_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !out_last) |=> !in_ready);

    // A generated byte holds while the MAC side stalls.
    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA && out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind eth_tx_pad_fcs txpf_checker u_txpf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last),
    .st        (state)
);

// File: tb/eth_tx_pad_fcs_test.sv
// Bench: sweeps frame lengths 1..70 over all flag pairs, with and without
// stalls and mid-frame flag flips; builds expected streams arithmetically.
module eth_tx_pad_fcs_test;

    localparam int MIN_DATA = 60;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_first, in_last, in_no_crc, in_no_pad;
    logic [7:0] in_data;
    logic       out_valid, out_ready, out_first, out_last;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    eth_tx_pad_fcs #(.MIN_DATA(MIN_DATA)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .in_no_crc(in_no_crc), .in_no_pad(in_no_pad),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] pattern_byte(input int len, input int i);
        return 8'((len * 7 + i * 13 + 5) & 255);
    endfunction

    task automatic run_frame(input int len, input bit nc, input bit np, input int pat);
        logic [7:0] exp_q[$];
        logic [7:0] got_q[$];
        logic [31:0] c;
        bit padded, with_fcs, done, in_all, rdy_bad, first_bad, ok;
        int i, cyc;
        string tag;
        padded   = !np && (len < MIN_DATA);
        with_fcs = padded || !nc;
        for (int k = 0; k < len; k++) exp_q.push_back(pattern_byte(len, k));
        if (padded) while (exp_q.size() < MIN_DATA) exp_q.push_back(8'h00);
        if (with_fcs) begin
            c = 32'hFFFFFFFF;
            foreach (exp_q[k]) c = ref_crc(c, exp_q[k]);
            c = ~c;
            for (int k = 0; k < 4; k++) exp_q.push_back(c[8*k +: 8]);
        end
        i = 0; cyc = 0; done = 0; in_all = 0; rdy_bad = 0; first_bad = 0;
        while (!done) begin
            @(negedge clk);
            in_valid  = (i < len) && (pat == 0 || (cyc % 3) != 0);
            in_data   = pattern_byte(len, i);
            in_first  = (i == 0);
            in_last   = (i == len - 1);
            in_no_crc = (i == 0 || pat == 0) ? nc : !nc;
            in_no_pad = (i == 0 || pat == 0) ? np : !np;
            out_ready = (pat == 0) || ((cyc % 4) != 1);
            #1;
            if (in_all && in_ready) rdy_bad = 1;
            if (in_valid && in_ready) begin
                i++;
                if (i == len) in_all = 1;
            end
            if (out_valid && out_ready) begin
                got_q.push_back(out_data);
                if (out_first != (got_q.size() == 1)) first_bad = 1;
                if (out_last) done = 1;
            end
            cyc++;
            if (cyc > 2000) begin
                check(0, "R8 watchdog", cyc, 2000);
                done = 1;
            end
        end
        @(negedge clk);
        in_valid = 0;
        ok = (got_q.size() == exp_q.size());
        if (ok) foreach (exp_q[k]) if (got_q[k] !== exp_q[k]) ok = 0;
        if (padded)        tag = nc ? "R3 forced FCS" : "R2 pad";
        else if (with_fcs) tag = "R4 FCS";
        else               tag = "R5 no FCS";
        check(ok, tag, got_q.size(), exp_q.size());
        if (np && len < MIN_DATA)
            check(got_q.size() == len + (with_fcs ? 4 : 0), "R6 no pad", got_q.size(), len + (with_fcs ? 4 : 0));
        if (len >= MIN_DATA)
            check(got_q.size() == len + (with_fcs ? 4 : 0), "R9 long frame", got_q.size(), len + (with_fcs ? 4 : 0));
        check(!first_bad, "R1 start marker", first_bad, 0);
        check(!rdy_bad, "R8 input stall", rdy_bad, 0);
        if (pat != 0) begin
            check(ok, "R7 flags after first beat", got_q.size(), exp_q.size());
            check(ok, "R10 stalled output", got_q.size(), exp_q.size());
        end
    endtask

    initial begin
        rst_n = 0; in_valid = 0; in_data = 0; in_first = 0; in_last = 0;
        in_no_crc = 0; in_no_pad = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        check(in_ready == 1, "R1 reset in_ready", in_ready, 1);
        for (int pat = 0; pat < 2; pat++)
            for (int len = 1; len <= 70; len++)
                for (int f = 0; f < 4; f++)
                    run_frame(len, f[0], f[1], pat);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule